// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block turns a physical memory address into the DRAM chip-select row that holds it. Software programs eight cumulative row-boundary values, each the top of a row counted in 64 MiB steps. It also programs a packed page-size attribute per row and a controller mode word, from which the decoder takes the channel mode and the ECC mode. Row 0 starts at address zero. Every later row starts where the one below it ends. A row whose boundary equals the boundary below it holds no memory and is never picked.

A decode request is one address with a valid strobe. One clock later the block returns the selected row, a hit flag or an out-of-range flag, the page-size code of that row, an ECC flag and the channel mode in force. In dual-channel mode only the lower half of the rows take part. Configuration goes through a single-cycle write port. A write lands on the clock edge that ends its cycle, so a decode issued in the same cycle still sees the old settings.

Top module: `dram_row_decoder`

## Requirements
- R1: A boundary write (`cfg_sel`=0, `cfg_idx` = row) stores `cfg_wdata[6:0]` as that row's top in 64 MiB units; `cfg_wdata[7]` is reserved and has no effect on decoding.
- R2: With the address's 64 MiB index taken as `dec_addr[35:26]`, row i is selected for indexes from the boundary of row i-1 (zero for row 0) up to its own boundary minus one; address bits below bit 26 do not affect the result.
- R3: A row whose boundary equals the boundary of the row below it is empty and is never reported; the decode goes to the next higher row that covers the index.
- R4: An attribute write (`cfg_sel`=1, `cfg_idx` = k) sets the code of row 2k from `cfg_wdata[2:0]` and the code of row 2k+1 from `cfg_wdata[6:4]`; on a hit, `res_page_attr` gives the code of the selected row (0=4 KiB, 1=8 KiB, 2=16 KiB, 3=32 KiB).
- R5: An index at or above the highest active boundary gives `res_oor`=1, `res_hit`=0, `res_row`=0, `res_page_attr`=0 and `res_ecc`=0.
- R6: A mode write (`cfg_sel`=2) with `cfg_wdata[21]`=1 selects dual-channel mode, where only rows 0 to 3 decode and `res_dual`=1; with bit 21 clear, all eight rows decode and `res_dual`=0.
- R7: `res_ecc` is 1 exactly when the decode hits and the mode word's bits 19:18 equal 01; any other value of that field gives 0.
- R8: Results appear with `res_valid` in the cycle after `dec_valid` and stay unchanged while `dec_valid` is low; a write in the same cycle as a decode does not affect that decode, only later ones.
- R9: After reset, `res_valid` is 0 and all boundaries, attributes and mode bits are zero, so every address is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 boundary, 1 attribute byte, 2 mode word |
| cfg_idx | input | 3 | Row number for boundaries, byte number for attributes |
| cfg_wdata | input | 32 | Write data |
| dec_valid | input | 1 | Decode request strobe |
| dec_addr | input | 36 | Physical address to decode |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_row | output | 3 | Selected row, 0 when out of range |
| res_hit | output | 1 | Address falls in a populated active row |
| res_oor | output | 1 | Address is above all active memory |
| res_page_attr | output | 3 | Page-size code of the selected row |
| res_ecc | output | 1 | ECC applies to the selected row |
| res_dual | output | 1 | Dual-channel mode was in force |

## Verification
The bench programs empty rows at two places in the row stack and decodes indexes on both sides of each boundary. A decoder that did not skip empty rows, or that compared with greater-or-equal, would report the empty row or the row one too low. Writing a boundary with bit 7 set and decoding just above its low seven bits catches a design that keeps the reserved bit, because it would report a hit where the address should be out of range. Dual mode is probed with an index that only row 5 covers, which a decoder that ignores the channel mode would report as a hit. A write issued in the same cycle as a decode checks that the design does not forward the new value into that decode.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
  typedef enum logic [1:0] {
    CFG_BOUND = 2'd0,
    CFG_ATTR  = 2'd1,
    CFG_MODE  = 2'd2
  } cfg_sel_e;

  localparam int MODE_DUAL_BIT = 21;
  localparam int MODE_ECC_LSB  = 18;
  localparam logic [1:0] ECC_ON_CODE = 2'b01;
  localparam int ATTR_SLOT = 4;
endpackage

// File: rtl/dram_row_regs.sv
module dram_row_regs
  import dram_row_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 7,
  parameter int ATTR_W   = 3,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [NUM_ROWS*BND_W-1:0]  bnd_flat,
  output logic [NUM_ROWS*ATTR_W-1:0] attr_flat,
  output logic                       mode_dual,
  output logic [1:0]                 mode_ecc
);
  logic bnd_wr, attr_wr, mode_wr;
  logic [BND_W-1:0]  bnd_q  [NUM_ROWS];
  logic [ATTR_W-1:0] attr_q [NUM_ROWS];
  logic [NUM_ROWS-1:0] bnd_en, attr_en;
  logic dual_d;
  logic [1:0] ecc_d;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    bnd_wr  = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_BOUND);
    attr_wr = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_ATTR);
    mode_wr = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_MODE);
    dual_d  = cfg_wdata[MODE_DUAL_BIT];
    ecc_d   = cfg_wdata[MODE_ECC_LSB +: 2];
  end

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    always_comb begin
      bnd_en[g]  = bnd_wr  && (cfg_idx == IDX_W'(g));
      attr_en[g] = attr_wr && (cfg_idx == IDX_W'(g / 2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bnd_q[g]  <= '0;
        attr_q[g] <= '0;
      end else begin
        if (bnd_en[g])  bnd_q[g]  <= cfg_wdata[BND_W-1:0];
        if (attr_en[g]) attr_q[g] <= cfg_wdata[(g % 2) * ATTR_SLOT +: ATTR_W];
      end
    end

    assign bnd_flat[g*BND_W +: BND_W]    = bnd_q[g];
    assign attr_flat[g*ATTR_W +: ATTR_W] = attr_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_dual <= 1'b0;
      mode_ecc  <= 2'b00;
    end else if (mode_wr) begin
      mode_dual <= dual_d;
      mode_ecc  <= ecc_d;
    end
  end

  // R1: a boundary write to row 0 lands with the reserved bit dropped
  p_bnd_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_wr && cfg_idx == '0) |=> (bnd_flat[BND_W-1:0] == $past(cfg_wdata[BND_W-1:0])));

  // R4: an attribute write to byte 0 fills rows 0 and 1 from their slots
  p_attr_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_wr && cfg_idx == '0) |=>
      (attr_flat[ATTR_W-1:0] == $past(cfg_wdata[ATTR_W-1:0]) &&
       attr_flat[2*ATTR_W-1:ATTR_W] == $past(cfg_wdata[ATTR_SLOT +: ATTR_W])));
endmodule

// File: rtl/dram_row_match.sv
module dram_row_match #(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 7,
  parameter int IX_W     = 10,
  localparam int IDX_W   = $clog2(NUM_ROWS),
  localparam int CMP_W   = (IX_W > BND_W) ? IX_W : BND_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IX_W-1:0]           addr_ix,
  input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
  input  logic                      dual,
  output logic                      found,
  output logic [IDX_W-1:0]          row
);
  localparam int HALF_ROWS = NUM_ROWS / 2;

  logic [NUM_ROWS-1:0] above;
  logic [NUM_ROWS-1:0] active;
  logic [CMP_W-1:0]    ix_ext;
  logic [CMP_W-1:0]    lower_bnd;

  assign ix_ext = CMP_W'(addr_ix);

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_cmp
    if (g < HALF_ROWS) begin : g_low
      assign active[g] = 1'b1;
    end else begin : g_high
      assign active[g] = !dual;
    end
    assign above[g] = active[g] && (CMP_W'(bnd_flat[g*BND_W +: BND_W]) > ix_ext);
  end

  // Lowest active row whose top lies above the index; empty rows lose to
  // the row below them because that row has the same top.
  always_comb begin
    found = 1'b0;
    row   = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (above[i]) begin
        found = 1'b1;
        row   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    lower_bnd = '0;
    for (int i = 1; i < NUM_ROWS; i++) begin
      if (row == IDX_W'(i)) lower_bnd = CMP_W'(bnd_flat[(i-1)*BND_W +: BND_W]);
    end
  end

  // R2: the index is never below the start of the selected row
  p_lower_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (lower_bnd <= ix_ext));

  // R6: dual-channel decodes stay in the lower half of the rows
  p_dual_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (found && dual) |-> (row < IDX_W'(HALF_ROWS)));
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
  import dram_row_pkg::*;
#(
  parameter int NUM_ROWS    = 8,
  parameter int ADDR_W      = 36,
  parameter int GRAIN_SHIFT = 26,
  parameter int BND_W       = 7,
  parameter int ATTR_W      = 3,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ROWS),
  localparam int IX_W       = ADDR_W - GRAIN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_addr,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_row,
  output logic              res_hit,
  output logic              res_oor,
  output logic [ATTR_W-1:0] res_page_attr,
  output logic              res_ecc,
  output logic              res_dual
);
  logic [NUM_ROWS*BND_W-1:0]  bnd_flat;
  logic [NUM_ROWS*ATTR_W-1:0] attr_flat;
  logic                       mode_dual;
  logic [1:0]                 mode_ecc;
  logic                       found;
  logic [IDX_W-1:0]           match_row;
  logic [IDX_W-1:0]           row_d;
  logic [ATTR_W-1:0]          attr_d;
  logic                       ecc_d;
  logic                       unused_lo;

  assign unused_lo = ^dec_addr[GRAIN_SHIFT-1:0];

  dram_row_regs #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .bnd_flat(bnd_flat),
    .attr_flat(attr_flat), .mode_dual(mode_dual), .mode_ecc(mode_ecc)
  );

  dram_row_match #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .IX_W(IX_W)
  ) i_match (
    .clk(clk), .rst_n(rst_n), .addr_ix(dec_addr[ADDR_W-1:GRAIN_SHIFT]),
    .bnd_flat(bnd_flat), .dual(mode_dual), .found(found), .row(match_row)
  );

  always_comb begin
    row_d  = found ? match_row : '0;
    attr_d = found ? attr_flat[match_row*ATTR_W +: ATTR_W] : '0;
    ecc_d  = found && (mode_ecc == ECC_ON_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= dec_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_row       <= '0;
      res_hit       <= 1'b0;
      res_oor       <= 1'b0;
      res_page_attr <= '0;
      res_ecc       <= 1'b0;
      res_dual      <= 1'b0;
    end else if (dec_valid) begin
      res_row       <= row_d;
      res_hit       <= found;
      res_oor       <= !found;
      res_page_attr <= attr_d;
      res_ecc       <= ecc_d;
      res_dual      <= mode_dual;
    end
  end

  // R5: a miss reports row 0 with no attribute and no ECC
  p_miss_row0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_oor) |-> (res_row == '0 && !res_hit && res_page_attr == '0 && !res_ecc));

  // R7: the ECC flag only rides on a hit
  p_ecc_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_ecc |-> res_hit);

  // R8: one-cycle latency of the valid strobe
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> res_valid);

  // R8: results hold while no decode is requested
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(res_row) && $stable(res_hit) && $stable(res_page_attr) && !res_valid));
endmodule

// File: tb/test_dram_row_decoder.sv
`timescale 1ns/1ps
module test_dram_row_decoder;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        dec_valid;
  logic [35:0] dec_addr;
  logic        res_valid;
  logic [2:0]  res_row;
  logic        res_hit;
  logic        res_oor;
  logic [2:0]  res_page_attr;
  logic        res_ecc;
  logic        res_dual;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] row;
    logic       hit;
    logic       oor;
    logic [2:0] attr;
    logic       ecc;
    logic       dual;
    string      req;
  } exp_t;

  exp_t exp_q[$];

  logic [6:0] m_bnd [8];
  logic [2:0] m_attr [8];
  logic       m_dual;
  logic       m_ecc;

  dram_row_decoder i_dram_row_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .dec_valid(dec_valid),
    .dec_addr(dec_addr), .res_valid(res_valid), .res_row(res_row),
    .res_hit(res_hit), .res_oor(res_oor), .res_page_attr(res_page_attr),
    .res_ecc(res_ecc), .res_dual(res_dual)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic exp_t model(int ix, string req);
    exp_t e;
    int lim;
    e.row = 0; e.hit = 0; e.oor = 1; e.attr = 0; e.ecc = 0;
    e.dual = m_dual; e.req = req;
    lim = m_dual ? 4 : 8;
    for (int r = 0; r < lim; r++) begin
      if (!e.hit && int'(m_bnd[r]) > ix) begin
        e.row = 3'(r); e.hit = 1; e.oor = 0;
      end
    end
    if (e.hit) begin
      e.attr = m_attr[e.row];
      e.ecc  = m_ecc;
    end
    return e;
  endfunction

  task automatic fail_line(string req, string what, int act, int expv);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
  endtask

  // Monitor: pop and compare each result as it appears
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fail_line("R8", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (res_row !== e.row || res_hit !== e.hit || res_oor !== e.oor ||
            res_page_attr !== e.attr || res_ecc !== e.ecc || res_dual !== e.dual) begin
          errors++;
          $display("FAIL %s actual row=%0d hit=%0d oor=%0d attr=%0d ecc=%0d dual=%0d expected row=%0d hit=%0d oor=%0d attr=%0d ecc=%0d dual=%0d",
                   e.req, res_row, res_hit, res_oor, res_page_attr, res_ecc, res_dual,
                   e.row, e.hit, e.oor, e.attr, e.ecc, e.dual);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    cfg_we = 0; dec_valid = 0;
  endtask

  task automatic wr(logic [1:0] sel, int idx, logic [31:0] data);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_idx = 3'(idx); cfg_wdata = data; dec_valid = 0;
    if (sel == 2'd0) m_bnd[idx] = data[6:0];
    if (sel == 2'd1) begin
      m_attr[2*idx]   = data[2:0];
      m_attr[2*idx+1] = data[6:4];
    end
    if (sel == 2'd2) begin
      m_dual = data[21];
      m_ecc  = (data[19:18] == 2'b01);
    end
  endtask

  task automatic dec(int ix, logic [25:0] off, string req);
    @(posedge clk); #1;
    cfg_we = 0; dec_valid = 1;
    dec_addr = {10'(ix), off};
    exp_q.push_back(model(ix, req));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_bnd[i] = 0; m_attr[i] = 0; end
    m_dual = 0; m_ecc = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_wdata = 0;
    dec_valid = 0; dec_addr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) fail_line("R9", "res_valid after reset", res_valid, 0);

    // R9: all-zero boundaries put every address out of range
    dec(0, 26'h0, "R9");
    dec(3, 26'h123, "R9");

    // Boundaries: rows 1 and 4 empty (R3); row 7 written with bit 7 set (R1)
    wr(2'd0, 0, 32'h02); wr(2'd0, 1, 32'h02); wr(2'd0, 2, 32'h05);
    wr(2'd0, 3, 32'h06); wr(2'd0, 4, 32'h06); wr(2'd0, 5, 32'h09);
    wr(2'd0, 6, 32'h0C); wr(2'd0, 7, 32'h8F);
    // R4: attributes with reserved bits 3 and 7 set in byte 0
    wr(2'd1, 0, 32'hA9); wr(2'd1, 1, 32'h30); wr(2'd1, 2, 32'h12); wr(2'd1, 3, 32'h03);
    wr(2'd2, 0, 32'h0004_0000);

    dec(0, 26'h0, "R2");
    dec(1, 26'h3FF_FFFF, "R2");
    dec(2, 26'h0, "R3");
    dec(4, 26'h3FF_FFFF, "R4");
    dec(5, 26'h0, "R4");
    dec(6, 26'h0, "R3");
    dec(8, 26'h155_5555, "R2");
    dec(9, 26'h0, "R4");
    dec(12, 26'h0, "R4");
    dec(14, 26'h3FF_FFFF, "R1");
    dec(15, 26'h0, "R1");
    dec(1000, 26'h0, "R5");
    idle(); idle();
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) fail_line("R8", "res_valid while idle", res_valid, 0);

    // R7: ECC field 11 does not enable the flag
    wr(2'd2, 0, 32'h000C_0000);
    dec(0, 26'h0, "R7");
    // R6: dual channel with ECC on
    wr(2'd2, 0, 32'h0024_0000);
    dec(5, 26'h0, "R6");
    dec(6, 26'h0, "R6");
    dec(9, 26'h0, "R6");
    wr(2'd2, 0, 32'h0004_0000);
    dec(9, 26'h0, "R6");

    // R8: a write in the decode cycle is not seen by that decode
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 2'd0; cfg_idx = 3'd7; cfg_wdata = 32'h14;
    dec_valid = 1; dec_addr = {10'd15, 26'h0};
    exp_q.push_back(model(15, "R8"));
    m_bnd[7] = 7'h14;
    dec(15, 26'h0, "R8");
    idle(); idle(); idle();

    checks++;
    if (exp_q.size() != 0) fail_line("R8", "results missing", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule